// File: doc/BRIEF.md
# Soft-Start Reference Ramp Generator

This block produces the digital reference code that a switching regulator's feedback comparator uses while the regulator starts up. Once the block is enabled and out of power-on reset, it raises the code from zero towards a fixed regulation setpoint. It takes one small step for each pulse of a slow pacing tick. The code is expressed in 0.1 mV units. It rises by 12 units per tick and is clipped at 5000 units, which is the 500 mV setpoint. At 2 µs per tick, the full ramp takes 417 ticks, about 834 µs.

When the code reaches the setpoint, the block stops using the ramp register and outputs the fixed setpoint. At the same time it raises a completion flag. For as long as the ramp is running, the block passes the regulator's zero-current indication through as a request to switch the low-side transistor off. This gives diode-emulation behaviour during start-up whatever the power-save setting is, so the regulator can start into an output that already carries a voltage. Either taking the enable away or asserting power-on reset sends the ramp back to zero.

Top module: `ssramp_top`

## Requirements
- R1: While `rst_n` is low and after it is released, `ref_code` is 0 and `ss_done` is 0 until the first advancing tick.
- R2: With `en` high, `por` low and `ss_done` low, a clock edge with `tick` high raises `ref_code` by 12. A clock edge with `tick` low leaves `ref_code` unchanged.
- R3: `ref_code` never exceeds 5000. A step that would pass 5000 lands exactly on 5000.
- R4: `ss_done` goes high on the same clock edge at which `ref_code` first becomes 5000.
- R5: Once `ss_done` is high, further ticks have no effect while `en` stays high and `por` stays low. `ref_code` holds at 5000 and `ss_done` stays high.
- R6: `ls_off_req` is high exactly when `en` is high, `ss_done` is low and `zero_cur` is high. This is combinational in the current cycle.
- R7: A clock edge with `en` low sets `ref_code` to 0 and `ss_done` to 0, and any tick present at that edge is ignored.
- R8: A clock edge with `por` high sets `ref_code` to 0 and `ss_done` to 0, even when `tick` is high. After `por` is released, the ramp restarts from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Regulator enable; low clears the ramp |
| tick | input | 1 | Single-cycle pacing pulse (500 kHz rate) |
| zero_cur | input | 1 | Inductor current has reached zero |
| por | input | 1 | Synchronous power-on reset; clears the ramp |
| ref_code | output | 13 | Reference code in 0.1 mV units |
| ss_done | output | 1 | Soft-start complete flag |
| ls_off_req | output | 1 | Request to turn the low-side switch off |

## Verification
A wrong ramp register shows up on `ref_code` at the first clock edge after the fault. The bench compares it against a model at every cycle, so an error in the step size, a missed clip or a lost clear is reported within one cycle. A wrong completion state shows up in two places in the same cycle: on `ss_done`, and on `ls_off_req`, which stays gated or stops being gated too early whenever `zero_cur` is high. Asserting `por` together with a tick, and dropping `en` together with a tick, expose priority errors on the very next edge.

// File: rtl/ssramp_pkg.sv
package ssramp_pkg;

  // Saturating add: cur + step, clipped to limit.
  function automatic int unsigned sat_add(input int unsigned cur,
                                          input int unsigned step,
                                          input int unsigned limit);
    int unsigned sum;
    sum = cur + step;
    return (sum > limit) ? limit : sum;
  endfunction

endpackage

// File: rtl/ssramp_stepper.sv
module ssramp_stepper #(
  parameter int unsigned CODE_W   = 13,
  parameter int unsigned STEP     = 12,
  parameter int unsigned SETPOINT = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [CODE_W-1:0] ramp_q,
  output logic [CODE_W-1:0] ramp_nxt
);

  // Next ramp value, already clipped at the setpoint.
  assign ramp_nxt = CODE_W'(ssramp_pkg::sat_add(32'(ramp_q), STEP, SETPOINT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ramp_q <= '0;
    else if (clr) ramp_q <= '0;
    else if (adv) ramp_q <= ramp_nxt;
  end

endmodule

// File: rtl/ssramp_handoff.sv
module ssramp_handoff #(
  parameter int unsigned CODE_W   = 13,
  parameter int unsigned SETPOINT = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [CODE_W-1:0] ramp_q,
  input  logic [CODE_W-1:0] ramp_nxt,
  output logic              done_q,
  output logic [CODE_W-1:0] ref_code
);

  localparam logic [CODE_W-1:0] SET_CODE = CODE_W'(SETPOINT);

  logic reach_evt;
  assign reach_evt = adv && (ramp_nxt == SET_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         done_q <= 1'b0;
    else if (clr)       done_q <= 1'b0;
    else if (reach_evt) done_q <= 1'b1;
  end

  // Once complete, the fixed setpoint replaces the ramp register.
  assign ref_code = done_q ? SET_CODE : ramp_q;

endmodule

// File: rtl/ssramp_lsgate.sv
module ssramp_lsgate (
  input  logic en,
  input  logic done_q,
  input  logic zero_cur,
  output logic ls_off_req
);

  logic ramp_active;
  assign ramp_active = en && !done_q;
  assign ls_off_req  = ramp_active && zero_cur;

endmodule

// File: rtl/ssramp_top.sv
module ssramp_top #(
  parameter int unsigned CODE_W   = 13,
  parameter int unsigned STEP     = 12,
  parameter int unsigned SETPOINT = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              zero_cur,
  input  logic              por,
  output logic [CODE_W-1:0] ref_code,
  output logic              ss_done,
  output logic              ls_off_req
);

  logic              clr_evt;
  logic              step_evt;
  logic [CODE_W-1:0] ramp_q;
  logic [CODE_W-1:0] ramp_nxt;

  // Power-on reset and disable both clear; they win over a tick.
  assign clr_evt  = por || !en;
  assign step_evt = tick && !clr_evt && !ss_done;

  ssramp_stepper #(
    .CODE_W(CODE_W), .STEP(STEP), .SETPOINT(SETPOINT)
  ) stepper_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_evt), .adv(step_evt),
    .ramp_q(ramp_q), .ramp_nxt(ramp_nxt)
  );

  ssramp_handoff #(
    .CODE_W(CODE_W), .SETPOINT(SETPOINT)
  ) handoff_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_evt), .adv(step_evt),
    .ramp_q(ramp_q), .ramp_nxt(ramp_nxt),
    .done_q(ss_done), .ref_code(ref_code)
  );

  ssramp_lsgate lsgate_i (
    .en(en), .done_q(ss_done), .zero_cur(zero_cur), .ls_off_req(ls_off_req)
  );

endmodule

// File: rtl/ssramp_chk.sv
module ssramp_chk #(
  parameter int unsigned CODE_W   = 13,
  parameter int unsigned SETPOINT = 5000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              tick,
  input logic              zero_cur,
  input logic              por,
  input logic [CODE_W-1:0] ref_code,
  input logic              ss_done,
  input logic              ls_off_req,
  input logic              step_evt
);

  AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    ref_code <= CODE_W'(SETPOINT)); // R3

  AST_STEP_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (ref_code > $past(ref_code))); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !por && !tick) |=> $stable(ref_code)); // R2

  AST_DONE_AT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> (ref_code == CODE_W'(SETPOINT))); // R4

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_done && en && !por) |=> ss_done); // R5

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ref_code == '0 && !ss_done)); // R7

  AST_POR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    por |=> (ref_code == '0 && !ss_done)); // R8

  AST_LS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ls_off_req |-> (zero_cur && en && !ss_done)); // R6

endmodule

bind ssramp_top ssramp_chk #(.CODE_W(CODE_W), .SETPOINT(SETPOINT)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .zero_cur(zero_cur),
  .por(por), .ref_code(ref_code), .ss_done(ss_done),
  .ls_off_req(ls_off_req), .step_evt(step_evt)
);

// File: tb/ssramp_tb.sv
`timescale 1ns/1ps
module ssramp_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        tick = 1'b0;
  logic        zero_cur = 1'b0;
  logic        por = 1'b0;
  logic [12:0] ref_code;
  logic        ss_done;
  logic        ls_off_req;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Behavioural model state
  int m_code = 0;
  int m_done = 0;

  always #2.5 clk = ~clk;

  ssramp_top dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .zero_cur(zero_cur),
    .por(por), .ref_code(ref_code), .ss_done(ss_done), .ls_off_req(ls_off_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock cycle: check registered outputs, drive inputs, check the
  // combinational request, then advance the model across the edge.
  task automatic cyc(input bit e, input bit t, input bit z, input bit p, input string tag);
    @(negedge clk);
    check({tag, " ref_code"}, int'(ref_code), m_code);
    check({tag, " ss_done"}, int'(ss_done), m_done);
    en = e; tick = t; zero_cur = z; por = p;
    #0.5;
    check("R6 ls_off_req", int'(ls_off_req), (e && m_done == 0 && z) ? 1 : 0);
    @(posedge clk);
    if (!e || p) begin
      m_code = 0; m_done = 0;
    end else if (t && m_done == 0) begin
      m_code = m_code + 12;
      if (m_code > 5000) m_code = 5000;
      if (m_code == 5000) m_done = 1;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset ref_code", int'(ref_code), 0);
    check("R1 reset ss_done", int'(ss_done), 0);
    rst_n = 1'b1;
    // R1/R2: enabled but no ticks, code holds at zero
    for (int i = 0; i < 5; i++) cyc(1, 0, i[0], 0, "R1");
    // R2/R3/R4: full ramp, tick every other cycle, varying zero_cur
    n = 0;
    while (m_done == 0 && n < 2000) begin
      cyc(1, 1, (n % 3) == 0, 0, "R2");
      cyc(1, 0, (n % 3) == 1, 0, "R2");
      n++;
    end
    check("R3 ticks to setpoint", n, 417);
    check("R4 final code", m_code, 5000);
    // R5: ticks after completion ignored, ls request off
    for (int i = 0; i < 10; i++) cyc(1, 1, 1, 0, "R5");
    // R7: disable with tick present
    cyc(0, 1, 1, 0, "R7");
    for (int i = 0; i < 6; i++) cyc(0, i[0], 1, 0, "R7");
    // Partial ramp, then por together with tick
    for (int i = 0; i < 50; i++) cyc(1, 1, i[1], 0, "R2");
    cyc(1, 1, 1, 1, "R8");
    cyc(1, 1, 1, 1, "R8");
    // R8: restart from zero and ramp fully again with back-to-back ticks
    n = 0;
    while (m_done == 0 && n < 2000) begin
      cyc(1, 1, n[0], 0, "R8");
      n++;
    end
    check("R8 restart ticks", n, 417);
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0, "R5");
    cyc(0, 0, 1, 0, "R7");
    cyc(1, 0, 1, 0, "R7");
    cyc(1, 0, 0, 0, "R7");
    finish_run();
  end

endmodule